// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a cycle-accurate digital model of a clocked charge-balance voltage-to-frequency loop. A signed accumulator takes the place of the analog integrator. On every rising clock edge it adds an unsigned input magnitude. On each discharge cycle it also takes away a fixed reference magnitude. A comparator checks whether the accumulator is at or above zero. That result is gated off while a discharge is in progress. The gated result is sampled on the falling clock edge and then passed to a latch on the following rising edge. The latch output is both the discharge command and the block's output pulse.

Because the latch can only change state on rising edges, every output pulse is exactly one clock long. The spacing between pulses is always a whole number of clocks. Over a long window, the number of pulses times the reference equals the total input charge, to within the accumulator's bounded swing. The clock therefore sets the full-scale rate, and counting pulses over a window derived from that same clock turns the block into an analog-to-digital measurement. The usable input range runs from zero to half the reference. At half the reference the loop pulses on every second clock.

Top module: `svfc_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `accOut` reads 0 and `pulseOut` reads 0 on the next rising edge. This holds even when reset is applied in the middle of a run.
- R2: `pulseOut` is never high on two consecutive rising edges. Every pulse lasts exactly one clock.
- R3: For inputs from 0 to REF/2, `accOut` always stays within [-REF, REF).
- R4: `pulseOut` can rise only when `accOut` was at or above zero just before that edge.
- R5: When `pulseOut` is low and `accOut` is negative, `pulseOut` stays low after the next rising edge.
- R6: When `pulseOut` is low and `accOut` is at or above zero, `pulseOut` is high after the next rising edge.
- R7: Over any run of N rising edges, the change in `accOut` equals N·din minus REF times the number of edges at which `pulseOut` was high just before the edge.
- R8: With `din` held from reset release, the number of pulses in N clocks, multiplied by REF, differs from N·din by less than 2·REF.
- R9: With everything else unchanged, the pulse count over a fixed window measured from reset never decreases as `din` increases.
- R10: When `din` = REF/4, consecutive pulses are exactly 4 clocks apart: one discharge clock followed by three integrate clocks.
- R11: When `din` is slightly above REF/4, consecutive pulses are 3 or 4 clocks apart. Gaps of 4 are the majority, and at least one gap of 3 occurs.
- R12: When `din` = REF/2, consecutive pulses are exactly 2 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the comparator is sampled on the falling edge and all other state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | IN_W | Unsigned input magnitude, added to the accumulator every clock |
| pulseOut | output | 1 | One-clock output pulse; also the discharge command |
| accOut | output | ACC_W | Signed accumulator value, for observation |

## Verification
The bound on the accumulator and the interval properties assume that `din` never exceeds REF/2. Above that value the loop cannot discharge as fast as charge arrives, and the accumulator would eventually wrap. The bench only ever drives values from 0 up to REF/2. It changes `din` only right after a rising edge, and only while reset is asserted or at the start of a run, so each window sees one constant input. Because every run begins from reset, all inputs start from the same state, and the pulse counts for neighbouring inputs can be compared directly.

// File: rtl/svfc_pkg.sv
package svfc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic discharge;  // subtract reference this cycle
    logic gateOpen;   // comparator result may pass
  } ctlStrb_t;
endpackage

// File: rtl/svfc_datapath.sv
module svfc_datapath
  import svfc_pkg::*;
#(
  parameter int REF   = 64,
  parameter int IN_W  = 7,
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         din,
  input  ctlStrb_t                strb,
  output logic                    gatedCmp,
  output logic signed [ACC_W-1:0] acc
);
  localparam int PAD_W = ACC_W - IN_W;
  localparam logic signed [ACC_W-1:0] REF_S = REF[ACC_W-1:0];

  logic signed [ACC_W-1:0] accQ;
  logic signed [ACC_W-1:0] accNext;
  logic signed [ACC_W-1:0] dinExt;
  logic signed [ACC_W-1:0] drain;
  logic                    aboveZero;

  always_comb begin
    dinExt  = signed'({{PAD_W{1'b0}}, din});
    drain   = strb.discharge ? REF_S : '0;
    accNext = accQ + dinExt - drain;
  end

  always_ff @(posedge clk) begin
    if (rst) accQ <= '0;
    else     accQ <= accNext;
  end

  assign aboveZero = ~accQ[ACC_W-1];
  assign gatedCmp  = aboveZero & strb.gateOpen;
  assign acc       = accQ;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (accQ >= -REF_S) && (accQ < REF_S));

  // R4
  rise_needs_charge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.discharge) |-> $past(aboveZero));

  // R5
  hold_when_negative_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.discharge && !aboveZero) |=> !strb.discharge);

  // R6
  fire_when_charged_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.discharge && aboveZero) |=> strb.discharge);
endmodule

// File: rtl/svfc_ctl.sv
module svfc_ctl
  import svfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     gatedCmp,
  output ctlStrb_t strb
);
  logic sampQ;   // falling-edge capture
  logic latchQ;  // rising-edge discharge latch

  always_ff @(negedge clk) begin
    if (rst) sampQ <= 1'b0;
    else     sampQ <= gatedCmp;
  end

  always_ff @(posedge clk) begin
    if (rst) latchQ <= 1'b0;
    else     latchQ <= sampQ;
  end

  always_comb begin
    strb.discharge = latchQ;
    strb.gateOpen  = ~latchQ;
  end

  // R2
  single_clock_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    latchQ |=> !latchQ);
endmodule

// File: rtl/svfc_top.sv
module svfc_top
  import svfc_pkg::*;
#(
  parameter int REF   = 64,
  parameter int IN_W  = 7,
  parameter int ACC_W = $clog2(REF) + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         din,
  output logic                    pulseOut,
  output logic signed [ACC_W-1:0] accOut
);
  ctlStrb_t strb;
  logic     gatedCmp;

  svfc_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .gatedCmp (gatedCmp),
    .strb     (strb)
  );

  svfc_datapath #(.REF(REF), .IN_W(IN_W), .ACC_W(ACC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .strb     (strb),
    .gatedCmp (gatedCmp),
    .acc      (accOut)
  );

  assign pulseOut = strb.discharge;
endmodule

// File: tb/sim_svfc_top.sv
module sim_svfc_top;
  localparam int REF   = 64;
  localparam int IN_W  = 7;
  localparam int ACC_W = $clog2(REF) + 2;
  localparam int NWIN  = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] din = '0;
  logic pulseOut;
  logic signed [ACC_W-1:0] accOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  svfc_top #(.REF(REF), .IN_W(IN_W)) u0 (
    .clk(clk), .rst(rst), .din(din), .pulseOut(pulseOut), .accOut(accOut)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input int val);
    rst = 1'b1;
    din = IN_W'(val);
    tick(); tick();
    rst = 1'b0;
  endtask

  // count pulses over NWIN edges from reset release; returns count and acc change
  task automatic runWindow(input int val, output int cnt, output int dAcc);
    int a0;
    restart(val);
    a0  = accOut;
    cnt = 0;
    for (int i = 0; i < NWIN; i++) begin
      if (pulseOut) cnt++;
      tick();
    end
    dAcc = int'(accOut) - a0;
  endtask

  // measure gaps between pulses after a settle period
  task automatic gaps(input int val, output int g2, output int g3,
                      output int g4, output int gOther);
    int last;
    restart(val);
    g2 = 0; g3 = 0; g4 = 0; gOther = 0; last = -1;
    for (int i = 0; i < 30; i++) tick();
    for (int i = 0; i < 300; i++) begin
      if (pulseOut) begin
        if (last >= 0) begin
          case (i - last)
            2: g2++;
            3: g3++;
            4: g4++;
            default: gOther++;
          endcase
        end
        last = i;
      end
      tick();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int cnt, dAcc, prevCnt, g2, g3, g4, gO;
    // R1: reset state
    din = IN_W'(20);
    tick(); tick();
    chk(accOut == 0, "R1 acc in reset", accOut, 0);
    chk(pulseOut == 1'b0, "R1 pulse in reset", pulseOut, 0);
    rst = 1'b0;
    for (int i = 0; i < 37; i++) tick();
    rst = 1'b1;
    tick();
    chk(accOut == 0, "R1 acc after mid-run reset", accOut, 0);
    chk(pulseOut == 1'b0, "R1 pulse after mid-run reset", pulseOut, 0);

    // R7, R8, R9 sweep over the full input range
    prevCnt = -1;
    for (int v = 0; v <= REF / 2; v++) begin
      runWindow(v, cnt, dAcc);
      chk(dAcc == NWIN * v - REF * cnt, "R7 charge balance", dAcc, NWIN * v - REF * cnt);
      chk((REF * cnt - NWIN * v < 2 * REF) && (NWIN * v - REF * cnt < 2 * REF),
          "R8 count accuracy", REF * cnt, NWIN * v);
      if (prevCnt >= 0)
        chk(cnt >= prevCnt, "R9 monotonic count", cnt, prevCnt);
      prevCnt = cnt;
    end

    // R10: quarter scale
    gaps(REF / 4, g2, g3, g4, gO);
    chk(g3 == 0 && g2 == 0 && gO == 0, "R10 only gaps of 4", g2 + g3 + gO, 0);
    chk(g4 > 50, "R10 gap-4 count", g4, 74);

    // R11: slightly above quarter scale
    gaps(REF / 4 + 1, g2, g3, g4, gO);
    chk(g2 == 0 && gO == 0, "R11 gaps limited to 3 or 4", g2 + gO, 0);
    chk(g3 >= 1, "R11 some gap of 3", g3, 1);
    chk(g4 > g3, "R11 gaps of 4 dominate", g4, g3);

    // R12: half scale
    gaps(REF / 2, g2, g3, g4, gO);
    chk(g3 == 0 && g4 == 0 && gO == 0, "R12 only gaps of 2", g3 + g4 + gO, 0);
    chk(g2 > 100, "R12 gap-2 count", g2, 149);

    // R2: pulses at half scale never touch
    restart(REF / 2);
    begin
      bit prevP = 1'b0;
      bit adj   = 1'b0;
      for (int i = 0; i < 100; i++) begin
        if (prevP && pulseOut) adj = 1'b1;
        prevP = pulseOut;
        tick();
      end
      chk(!adj, "R2 no back-to-back pulses", adj, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule